// File: doc/BRIEF.md
# Row Buffer Policy Bank Sequencer

This block drives the commands of one DRAM bank. It takes one access at a time, given as a row address and a read or write flag, and turns it into the short list of commands the bank needs. It keeps track of whether a row is latched in the bank's sense amplifiers and which row that is. From that state it issues an activate, a precharge, a column read or write, or a combination of these. Each column command moves one 64-byte block as eight 8-byte beats on consecutive cycles.

Two row-buffer management policies are available through a single select input. With the open-row policy, the row stays latched after each access. A later access to the same row then costs only a column command, and an access to a different row first pays for a precharge and an activate. With the closed-row policy, the bank is precharged after every access. The exception is a lookahead hint from the request queue, which says that a queued request wants the same row; in that case the row is left open so that the next access is a hit. Activate-to-column, activate-to-precharge and precharge-to-activate spacing are parameterised cycle gaps. Three counters record how each access was classified.

Top module: `rowpol_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid`, `beat_valid` and `done` are 0, all three counters are 0, and the bank holds no open row.
- R2: An access to a bank with no open row issues an activate carrying the request row, then a column command to that row, and increments `closed_cnt`. Command codes on `cmd_kind`: 0 none, 1 activate, 2 read, 3 write, 4 precharge. The column command is a write when `req_write` was 1 and a read otherwise.
- R3: An access whose row equals the open row issues only the column command and increments `hit_cnt`.
- R4: An access to a row other than the open row issues a precharge carrying the old row, an activate of the new row, then the column command, and increments `conflict_cnt`.
- R5: Under the open-row policy (`policy_closed`=0), no precharge follows an access and the row stays open, whatever the value of `same_row_pend`.
- R6: Under the closed-row policy with `same_row_pend`=0 at the end of the burst, a precharge of the accessed row follows the burst, and the next access finds the bank closed.
- R7: Under the closed-row policy with `same_row_pend`=1 at the end of the burst, no precharge is issued, and a following access to that row is a hit.
- R8: A column command is followed in the next eight cycles by `beat_valid` beats whose `beat_col` runs 0 to 7 in order.
- R9: A column command comes exactly T_RCD cycles after its activate. An activate that follows a precharge comes exactly T_RP cycles after it. A precharge comes at least T_RAS cycles after the activate of its row.
- R10: `req_ready` is high only while the sequencer is idle. `done` pulses for one cycle after the last command or beat of an access, and `req_ready` is high in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_closed | input | 1 | 1 selects the closed-row policy, 0 the open-row policy |
| req_valid | input | 1 | Request present |
| req_row | input | ROW_W | Row address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| same_row_pend | input | 1 | Lookahead hint: a queued request targets the same row |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 3 | Command code (see R2) |
| cmd_row | output | ROW_W | Row the command refers to |
| beat_valid | output | 1 | Data beat of the current column burst |
| beat_col | output | 3 | Column index of the beat within the block |
| done | output | 1 | One-cycle completion pulse |
| hit_cnt | output | CNT_W | Number of row-hit accesses |
| conflict_cnt | output | CNT_W | Number of row-conflict accesses |
| closed_cnt | output | CNT_W | Number of accesses to a closed bank |

## Verification
The bench runs access sequences that hit each of the three row states in turn: a first access to a closed bank, a repeat of the same row, and a jump to another row. It runs them under both policies and with the hint both high and low. Comparing the open policy with the hint high against the closed policy with the hint high shows whether the hint is honoured only where it should be. A closed-policy access with the hint low, followed by the same row, separates "precharged" from "left open" by whether an activate reappears. A wrong hint followed by a different row shows that a row left open by the hint is still treated as a conflict. Every access checks the exact command list, the rows carried, the activate and precharge spacing, the beat order and the counter deltas.

// File: rtl/rowpol_pkg.sv
package rowpol_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ACC_CLOSED   = 2'd0,
    ACC_HIT      = 2'd1,
    ACC_CONFLICT = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ACT   = 3'd2,
    ST_COL   = 3'd3,
    ST_BURST = 3'd4,
    ST_CLOSE = 3'd5,
    ST_FIN   = 3'd6
  } st_e;

  // Kind of access given the bank state and the row comparison.
  function automatic acc_e classify(input logic is_open, input logic row_match);
    if (!is_open)       return ACC_CLOSED;
    else if (row_match) return ACC_HIT;
    else                return ACC_CONFLICT;
  endfunction

  // Whether the row is closed once the burst ends.
  function automatic logic close_after(input logic pol_closed, input logic pend);
    return pol_closed && !pend;
  endfunction

  // Down-counter load that yields a gap of t cycles between two issues.
  function automatic int gap_load(input int t);
    return (t <= 1) ? 0 : t - 1;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rowpol_gap_timer.sv
module rowpol_gap_timer #(
  parameter int W    = 4,
  parameter int LOAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam logic [W-1:0] LD = W'(LOAD);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/rowpol_row_track.sv
module rowpol_row_track #(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic [ROW_W-1:0] set_row,
  input  logic             close,
  input  logic [ROW_W-1:0] lookup_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             row_match
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (open_set) begin
      is_open  <= 1'b1;
      open_row <= set_row;
    end else if (close) begin
      is_open  <= 1'b0;
    end
  end

  assign row_match = (lookup_row == open_row);
endmodule

// File: rtl/rowpol_beat_seq.sv
module rowpol_beat_seq #(
  parameter int BEATS = 8,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [COL_W-1:0] col,
  output logic             last
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      col    <= '0;
    end else if (start) begin
      active <= 1'b1;
      col    <= '0;
    end else if (active) begin
      if (col == LAST_COL) active <= 1'b0;
      else                 col    <= col + 1'b1;
    end
  end

  assign last = active && (col == LAST_COL);
endmodule

// File: rtl/rowpol_bank_seq.sv
module rowpol_bank_seq
  import rowpol_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 2,
  parameter int BEATS = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             policy_closed,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_write,
  input  logic             same_row_pend,
  output logic             req_ready,
  output logic             cmd_valid,
  output logic [2:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic             beat_valid,
  output logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] beat_col,
  output logic             done,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] conflict_cnt,
  output logic [CNT_W-1:0] closed_cnt
);
  localparam int COL_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int TMAX  = max3(T_RCD, T_RAS, T_RP);
  localparam int TMR_W = $clog2(TMAX + 1) + 1;
  localparam int NTMR  = 3;   // 0: act->col, 1: act->pre, 2: pre->act
  localparam int NCNT  = 3;   // 0: hit, 1: conflict, 2: closed

  st_e              st, st_n;
  logic [ROW_W-1:0] lat_row;
  logic             lat_wr;

  // Named internal events, brought out for the checker.
  logic             accept;
  logic             issue_act, issue_pre, issue_col;
  logic             bank_open, row_hit;
  logic [ROW_W-1:0] open_row;
  acc_e             req_class;
  logic             beat_last;
  logic             rcd_ok, ras_ok, rp_ok;
  cmd_e             cmd_k;

  // ---------------- row state ----------------
  rowpol_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_set   (issue_act),
    .set_row    (lat_row),
    .close      (issue_pre),
    .lookup_row (req_row),
    .is_open    (bank_open),
    .open_row   (open_row),
    .row_match  (row_hit)
  );

  assign req_class = classify(bank_open, row_hit);

  // ---------------- spacing timers ----------------
  logic [NTMR-1:0] tmr_start, tmr_ready;
  assign tmr_start = {issue_pre, issue_act, issue_act};

  generate
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      localparam int TV = (g == 0) ? T_RCD : (g == 1) ? T_RAS : T_RP;
      rowpol_gap_timer #(.W(TMR_W), .LOAD(gap_load(TV))) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start[g]),
        .ready (tmr_ready[g])
      );
    end
  endgenerate

  assign rcd_ok = tmr_ready[0];
  assign ras_ok = tmr_ready[1];
  assign rp_ok  = tmr_ready[2];

  // ---------------- data beats ----------------
  rowpol_beat_seq #(.BEATS(BEATS), .COL_W(COL_W)) u_beats (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (issue_col),
    .active (beat_valid),
    .col    (beat_col),
    .last   (beat_last)
  );

  // ---------------- sequencer ----------------
  assign accept = (st == ST_IDLE) && req_valid;

  always_comb begin
    st_n      = st;
    issue_act = 1'b0;
    issue_pre = 1'b0;
    issue_col = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          case (req_class)
            ACC_CLOSED: st_n = ST_ACT;
            ACC_HIT:    st_n = ST_COL;
            default:    st_n = ST_PRE;
          endcase
        end
      end
      ST_PRE: begin
        if (ras_ok) begin
          issue_pre = 1'b1;
          st_n      = ST_ACT;
        end
      end
      ST_ACT: begin
        if (rp_ok) begin
          issue_act = 1'b1;
          st_n      = ST_COL;
        end
      end
      ST_COL: begin
        if (rcd_ok) begin
          issue_col = 1'b1;
          st_n      = ST_BURST;
        end
      end
      ST_BURST: begin
        if (beat_last)
          st_n = close_after(policy_closed, same_row_pend) ? ST_CLOSE : ST_FIN;
      end
      ST_CLOSE: begin
        if (ras_ok) begin
          issue_pre = 1'b1;
          st_n      = ST_FIN;
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lat_row <= '0;
      lat_wr  <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) begin
        lat_row <= req_row;
        lat_wr  <= req_write;
      end
    end
  end

  // ---------------- command output ----------------
  always_comb begin
    if (issue_act)      cmd_k = CMD_ACT;
    else if (issue_pre) cmd_k = CMD_PRE;
    else if (issue_col) cmd_k = lat_wr ? CMD_WR : CMD_RD;
    else                cmd_k = CMD_NOP;
  end

  assign cmd_valid = issue_act || issue_pre || issue_col;
  assign cmd_kind  = cmd_k;
  assign cmd_row   = (issue_act || issue_col) ? lat_row :
                     issue_pre                ? open_row : '0;
  assign req_ready = (st == ST_IDLE);
  assign done      = (st == ST_FIN);

  // ---------------- access classification counters ----------------
  logic [NCNT-1:0]  cnt_inc;
  logic [CNT_W-1:0] cnt_q [NCNT];

  assign cnt_inc = {accept && (req_class == ACC_CLOSED),
                    accept && (req_class == ACC_CONFLICT),
                    accept && (req_class == ACC_HIT)};

  generate
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q[c] <= '0;
        else if (cnt_inc[c]) cnt_q[c] <= cnt_q[c] + 1'b1;
      end
    end
  endgenerate

  assign hit_cnt      = cnt_q[0];
  assign conflict_cnt = cnt_q[1];
  assign closed_cnt   = cnt_q[2];

endmodule

// File: rtl/rowpol_bank_chk.sv
module rowpol_bank_chk #(
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 2,
  parameter int COL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_kind,
  input logic             row_open,
  input logic             beat_valid,
  input logic [COL_W-1:0] beat_col,
  input logic             done,
  input logic             req_ready
);
  localparam int SW = 16;
  localparam logic [SW-1:0] SAT = '1;

  logic is_act, is_pre, is_col;
  assign is_act = cmd_valid && (cmd_kind == 3'd1);
  assign is_pre = cmd_valid && (cmd_kind == 3'd4);
  assign is_col = cmd_valid && ((cmd_kind == 3'd2) || (cmd_kind == 3'd3));

  // Cycles since the last activate and the last precharge (saturating).
  logic [SW-1:0] since_act, since_pre;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_pre <= SAT;
    end else begin
      since_act <= is_act ? SW'(1) : (since_act == SAT) ? SAT : since_act + 1'b1;
      since_pre <= is_pre ? SW'(1) : (since_pre == SAT) ? SAT : since_pre + 1'b1;
    end
  end

  // R2
  act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !row_open);

  // R3
  col_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> row_open);

  // R9
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act >= SW'(T_RCD));

  // R9
  ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> since_act >= SW'(T_RAS));

  // R9
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_pre >= SW'(T_RP));

  // R8
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |=> beat_valid && (beat_col == '0));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && (beat_col != '1)) |=> beat_valid && (beat_col == $past(beat_col) + 1'b1));

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready && !done);

endmodule

bind rowpol_bank_seq rowpol_bank_chk #(
  .T_RCD (T_RCD),
  .T_RAS (T_RAS),
  .T_RP  (T_RP),
  .COL_W (COL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_kind   (cmd_kind),
  .row_open   (bank_open),
  .beat_valid (beat_valid),
  .beat_col   (beat_col),
  .done       (done),
  .req_ready  (req_ready)
);

// File: tb/rowpol_bank_seq_test.sv
module rowpol_bank_seq_test;
  localparam int ROW_W = 14;
  localparam int T_RCD = 3;
  localparam int T_RAS = 6;
  localparam int T_RP  = 2;
  localparam int BEATS = 8;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             policy_closed = 1'b0;
  logic             req_valid = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic             req_write = 1'b0;
  logic             same_row_pend = 1'b0;
  logic             req_ready, cmd_valid, beat_valid, done;
  logic [2:0]       cmd_kind;
  logic [ROW_W-1:0] cmd_row;
  logic [2:0]       beat_col;
  logic [CNT_W-1:0] hit_cnt, conflict_cnt, closed_cnt;

  always #2.5 clk = ~clk;

  rowpol_bank_seq #(
    .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .BEATS(BEATS), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .policy_closed(policy_closed),
    .req_valid(req_valid), .req_row(req_row), .req_write(req_write),
    .same_row_pend(same_row_pend), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row),
    .beat_valid(beat_valid), .beat_col(beat_col), .done(done),
    .hit_cnt(hit_cnt), .conflict_cnt(conflict_cnt), .closed_cnt(closed_cnt)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Command and beat log, sampled away from the active edge.
  int kl[8], rl[8], cl[8];
  int n_ev = 0, n_beat = 0, first_beat = 0, beat_bad = 0;
  always @(negedge clk) begin
    if (cmd_valid && n_ev < 8) begin
      kl[n_ev] = int'(cmd_kind);
      rl[n_ev] = int'(cmd_row);
      cl[n_ev] = cyc;
      n_ev = n_ev + 1;
    end
    if (beat_valid) begin
      if (n_beat == 0) first_beat = cyc;
      if (int'(beat_col) != n_beat) beat_bad = beat_bad + 1;
      n_beat = n_beat + 1;
    end
  end

  // Reference model state.
  bit m_open = 0;
  int m_row = 0;
  int e_hit = 0, e_conf = 0, e_closed = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One access: drive, collect, compare with the model.
  task automatic access(input int row, input bit wr, input bit pend,
                        input bit pol, input string req);
    int ek[5]; int er[5]; int ne; int cls; int w; int ia; int ic; int ip;
    if (!m_open)          cls = 0;
    else if (m_row == row) cls = 1;
    else                  cls = 2;
    ne = 0;
    if (cls == 2) begin ek[ne] = 4; er[ne] = m_row; ne++; end
    if (cls != 1) begin ek[ne] = 1; er[ne] = row; ne++; end
    ek[ne] = wr ? 3 : 2; er[ne] = row; ne++;
    if (pol && !pend) begin ek[ne] = 4; er[ne] = row; ne++; end

    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    n_ev = 0; n_beat = 0; beat_bad = 0;
    policy_closed = pol; same_row_pend = pend;
    req_row = ROW_W'(row); req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done && w < 300) begin @(negedge clk); w++; end
    chk(done, "R10", "done seen", int'(done), 1);
    chk(!req_ready, "R10", "ready low during done", int'(req_ready), 0);
    @(negedge clk);
    chk(req_ready && !done, "R10", "ready after done", int'(req_ready), 1);

    chk(n_ev == ne, req, "command count", n_ev, ne);
    ia = -1; ic = -1; ip = -1;
    for (int i = 0; i < ne && i < n_ev; i++) begin
      chk(kl[i] == ek[i], req, $sformatf("cmd %0d kind", i), kl[i], ek[i]);
      chk(rl[i] == er[i], req, $sformatf("cmd %0d row", i), rl[i], er[i]);
      if (kl[i] == 1) ia = i;
      if (kl[i] == 2 || kl[i] == 3) ic = i;
      if (kl[i] == 4 && ia < 0) ip = i;
    end
    if (ia >= 0 && ic >= 0)
      chk(cl[ic] - cl[ia] == T_RCD, "R9", "act to column gap", cl[ic] - cl[ia], T_RCD);
    if (ia >= 0 && ip >= 0)
      chk(cl[ia] - cl[ip] == T_RP, "R9", "pre to act gap", cl[ia] - cl[ip], T_RP);
    if (ia >= 0 && n_ev == ne && kl[n_ev-1] == 4 && (n_ev - 1) > ia)
      chk(cl[n_ev-1] - cl[ia] >= T_RAS, "R9", "act to pre gap", cl[n_ev-1] - cl[ia], T_RAS);

    chk(n_beat == BEATS, "R8", "beat count", n_beat, BEATS);
    chk(beat_bad == 0, "R8", "beat order errors", beat_bad, 0);
    if (ic >= 0)
      chk(first_beat == cl[ic] + 1, "R8", "first beat cycle", first_beat, cl[ic] + 1);

    if (cls == 0) e_closed++;
    else if (cls == 1) e_hit++;
    else e_conf++;
    chk(int'(hit_cnt) == e_hit, "R3", "hit_cnt", int'(hit_cnt), e_hit);
    chk(int'(conflict_cnt) == e_conf, "R4", "conflict_cnt", int'(conflict_cnt), e_conf);
    chk(int'(closed_cnt) == e_closed, "R2", "closed_cnt", int'(closed_cnt), e_closed);

    m_open = !(pol && !pend);
    m_row = row;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready, "R1", "req_ready", int'(req_ready), 1);
    chk(!cmd_valid && !beat_valid && !done, "R1", "outputs idle",
        int'({cmd_valid, beat_valid, done}), 0);
    chk(hit_cnt == 0 && conflict_cnt == 0 && closed_cnt == 0, "R1", "counters",
        int'(hit_cnt) + int'(conflict_cnt) + int'(closed_cnt), 0);
  endtask

  task automatic t_open_policy();
    access(5, 0, 0, 0, "R2");    // closed bank: ACT + RD
    access(5, 1, 0, 0, "R3");    // hit: WR only
    access(9, 0, 0, 0, "R4");    // conflict: PRE + ACT + RD
  endtask

  task automatic t_open_ignores_hint();
    access(9, 0, 1, 0, "R5");    // hint high, open policy: no PRE
    access(9, 1, 0, 0, "R5");    // hint low, open policy: no PRE, still a hit
    access(12, 0, 0, 0, "R5");   // row stayed open: conflict
  endtask

  task automatic t_closed_policy();
    access(12, 0, 0, 1, "R6");   // hit then PRE
    access(12, 1, 1, 1, "R6");   // bank found closed: ACT again; hint keeps row
    access(12, 0, 1, 1, "R7");   // plain column, hit, still open
    access(12, 0, 0, 1, "R7");   // hit then PRE
    access(3, 1, 1, 1, "R7");    // closed access, left open by hint
    access(4, 0, 0, 1, "R4");    // wrong hint: conflict, then PRE
    access(4, 0, 0, 0, "R6");    // bank closed after the PRE
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_open_policy();
    t_open_ignores_hint();
    t_closed_policy();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule